// File: doc/BRIEF.md
# Serial CRC Generator and Checker

This block computes a cyclic redundancy code one bit per clock. A shift register of `WIDTH` bits, with XOR taps only where the generator polynomial has a nonzero coefficient, performs modulo-2 division. The generator's leading term is implied. Its remaining coefficients are given by the `POLY` parameter. The default is X^16+X^15+X^2+1, which is `POLY = 16'h8005`.

In generate mode the block takes a message, most significant bit first. After the last bit it shifts out the frame check sequence (FCS) over `WIDTH` cycles, also MSB first. The FCS is the remainder of the message extended by `WIDTH` zero bits, divided by the generator. Appended to the message, it makes a frame that the generator divides exactly.

In check mode the block takes a whole received frame, message followed by FCS, through the same division engine. It reports an error when the frame is not a multiple of the generator.

A new job begins with a one-cycle `start_i` pulse. The block holds its result until the next pulse.

Top module: `crc_serial_unit`

## Requirements
- R1: After reset, `done_o`, `err_o` and `fcs_vld_o` are 0.
- R2: In generate mode (`mode_i`=0), the cycle after the bit flagged by `bit_last_i` begins a run of exactly `WIDTH` cycles with `fcs_vld_o`=1. Over that run, `fcs_bit_o` presents the remainder of (message × X^WIDTH) ÷ generator, MSB first.
- R3: With `WIDTH`=4 and `POLY`=4'b0011 (generator 10011), message 1101011011 yields FCS 1110.
- R4: In generate mode, `done_o` rises in the cycle after the last FCS bit. In check mode, it rises in the cycle after the last frame bit. It then stays high, with `err_o` unchanged, until the next `start_i`. `err_o` is always 0 at the end of a generate job.
- R5: In check mode (`mode_i`=1), `err_o` is 1 exactly when the received frame leaves a nonzero remainder on division by the generator. A frame built from a message and its own FCS gives `err_o`=0.
- R6: Any single inverted bit in a valid frame is reported with `err_o`=1.
- R7: Any error burst no longer than `WIDTH` bits in a valid frame is reported with `err_o`=1.
- R8: In cycles with `bit_vld_i`=0, the values on `bit_i` and `bit_last_i` have no effect on the result.
- R9: `start_i` clears the remainder to zero and aborts any job in progress. In the following cycle, `done_o` and `fcs_vld_o` are 0. Input bits are taken from the cycle after `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that begins a job |
| mode_i | input | 1 | Job mode, sampled with `start_i`: 0 generate, 1 check |
| bit_vld_i | input | 1 | `bit_i` carries a message or frame bit this cycle |
| bit_i | input | 1 | Serial data bit, MSB first |
| bit_last_i | input | 1 | With `bit_vld_i`, marks the final input bit |
| fcs_vld_o | output | 1 | `fcs_bit_o` carries an FCS bit |
| fcs_bit_o | output | 1 | Serial FCS bit, MSB first |
| done_o | output | 1 | Job finished; held until the next `start_i` |
| err_o | output | 1 | Check mode: nonzero remainder; valid while `done_o` is high |

## Verification
The assertions assume `start_i` is a single-cycle pulse. They also assume that `bit_last_i` is raised together with `bit_vld_i` only while a job is taking bits, and that `POLY` has its constant term set. The bench keeps to this. It pulses `start_i` for exactly one clock and raises `bit_last_i` with a valid bit only on the final bit of each job. It randomizes `bit_i` and `bit_last_i` freely in cycles where `bit_vld_i` is low, and while the block sits in its done state, since both are then ignored.

// File: rtl/crc_ser_pkg.sv
package crc_ser_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DONE  = 2'd3
    } crc_state_e;

    typedef enum logic {
        MODE_GEN = 1'b0,
        MODE_CHK = 1'b1
    } crc_mode_e;

    // Controls passed from the sequencer to the division engine
    typedef struct packed {
        logic clr;
        logic step;
        logic drain;
    } eng_ctl_t;

    function automatic int unsigned cnt_width(input int unsigned w);
        return (w < 2) ? 1 : $clog2(w);
    endfunction

endpackage

// File: rtl/crc_div_engine.sv
module crc_div_engine
    import crc_ser_pkg::*;
#(
    parameter int unsigned WIDTH = 16,
    parameter logic [WIDTH-1:0] POLY = 16'h8005
) (
    input  logic     clk,
    input  logic     rst,
    input  eng_ctl_t ctl_i,
    input  logic     bit_i,
    output logic     msb_o,
    output logic     step_zero_o
);

    logic [WIDTH-1:0] rem_q;
    logic [WIDTH-1:0] shifted;
    logic [WIDTH-1:0] stepped;
    logic             fb;

    assign fb      = rem_q[WIDTH-1] ^ bit_i;
    assign shifted = {rem_q[WIDTH-2:0], 1'b0};

    // An XOR gate exists only where the polynomial has a term
    for (genvar i = 0; i < WIDTH; i++) begin : g_tap
        if (POLY[i]) begin : g_xor
            assign stepped[i] = shifted[i] ^ fb;
        end else begin : g_wire
            assign stepped[i] = shifted[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ctl_i.clr) begin
            rem_q <= '0;
        end else if (ctl_i.step) begin
            rem_q <= stepped;
        end else if (ctl_i.drain) begin
            rem_q <= shifted;
        end
    end

    assign msb_o       = rem_q[WIDTH-1];
    assign step_zero_o = (stepped == '0);

    // R8
    rem_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.clr && !ctl_i.step && !ctl_i.drain) |=> $stable(rem_q));

endmodule

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl
    import crc_ser_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     start_i,
    input  logic     mode_i,
    input  logic     bit_vld_i,
    input  logic     bit_last_i,
    input  logic     step_zero_i,
    output eng_ctl_t ctl_o,
    output logic     fcs_vld_o,
    output logic     done_o,
    output logic     err_o
);

    localparam int unsigned CW = cnt_width(WIDTH);
    localparam logic [CW-1:0] CNT_LAST = CW'(WIDTH - 1);

    crc_state_e      state_q;
    crc_mode_e       mode_q;
    logic [CW-1:0]   cnt_q;
    logic            err_q;
    logic            take_bit;

    assign take_bit = (state_q == ST_RUN) && bit_vld_i && !start_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= MODE_GEN;
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else if (start_i) begin
            state_q <= ST_RUN;
            mode_q  <= crc_mode_e'(mode_i);
            cnt_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            unique case (state_q)
                ST_RUN: begin
                    if (take_bit && bit_last_i) begin
                        if (mode_q == MODE_CHK) begin
                            state_q <= ST_DONE;
                            err_q   <= !step_zero_i;
                        end else begin
                            state_q <= ST_DRAIN;
                            cnt_q   <= '0;
                        end
                    end
                end
                ST_DRAIN: begin
                    if (cnt_q == CNT_LAST) begin
                        state_q <= ST_DONE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        ctl_o.clr   = start_i;
        ctl_o.step  = take_bit;
        ctl_o.drain = (state_q == ST_DRAIN) && !start_i;
    end

    assign fcs_vld_o = (state_q == ST_DRAIN);
    assign done_o    = (state_q == ST_DONE);
    assign err_o     = err_q;

    // R9
    start_clear_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!done_o && !fcs_vld_o));

    // R4
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (done_o && !start_i) |=> (done_o && $stable(err_o)));

    // R2
    drain_end_chk: assert property (@(posedge clk) disable iff (rst)
        (fcs_vld_o && cnt_q == CNT_LAST && !start_i) |=> (done_o && !err_o && !fcs_vld_o));

    // R5
    err_only_done_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |-> done_o);

endmodule

// File: rtl/crc_serial_unit.sv
module crc_serial_unit
    import crc_ser_pkg::*;
#(
    parameter int unsigned WIDTH = 16,
    parameter logic [WIDTH-1:0] POLY = 16'h8005
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic mode_i,
    input  logic bit_vld_i,
    input  logic bit_i,
    input  logic bit_last_i,
    output logic fcs_vld_o,
    output logic fcs_bit_o,
    output logic done_o,
    output logic err_o
);

    eng_ctl_t ctl;
    logic     step_zero;
    logic     msb;

    crc_seq_ctrl #(
        .WIDTH (WIDTH)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .mode_i      (mode_i),
        .bit_vld_i   (bit_vld_i),
        .bit_last_i  (bit_last_i),
        .step_zero_i (step_zero),
        .ctl_o       (ctl),
        .fcs_vld_o   (fcs_vld_o),
        .done_o      (done_o),
        .err_o       (err_o)
    );

    crc_div_engine #(
        .WIDTH (WIDTH),
        .POLY  (POLY)
    ) u_engine (
        .clk         (clk),
        .rst         (rst),
        .ctl_i       (ctl),
        .bit_i       (bit_i),
        .msb_o       (msb),
        .step_zero_o (step_zero)
    );

    assign fcs_bit_o = msb;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> (!done_o && !err_o && !fcs_vld_o));

endmodule

// File: tb/crc_serial_unit_tb.sv
module crc_serial_unit_tb;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0, mode_i = 1'b0, bit_vld_i = 1'b0, bit_i = 1'b0, bit_last_i = 1'b0;
    logic v16, b16, d16, e16;
    logic v4, b4, d4, e4;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    localparam logic [16:0] P16 = 17'h18005;
    localparam logic [16:0] P4  = 17'h00013;

    always #4 clk = ~clk;

    crc_serial_unit #(.WIDTH(16), .POLY(16'h8005)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .bit_vld_i(bit_vld_i), .bit_i(bit_i), .bit_last_i(bit_last_i),
        .fcs_vld_o(v16), .fcs_bit_o(b16), .done_o(d16), .err_o(e16));

    crc_serial_unit #(.WIDTH(4), .POLY(4'b0011)) u_dut_w4 (
        .clk(clk), .rst(rst), .start_i(start_i), .mode_i(mode_i),
        .bit_vld_i(bit_vld_i), .bit_i(bit_i), .bit_last_i(bit_last_i),
        .fcs_vld_o(v4), .fcs_bit_o(b4), .done_o(d4), .err_o(e4));

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Plain long division: bits[len-1] is sent first
    function automatic logic [15:0] ref_rem(input logic [16:0] pf, input int n,
                                            input logic [127:0] bits, input int len, input bit aug);
        logic [16:0] r = '0;
        int total = len + (aug ? n : 0);
        for (int i = 0; i < total; i++) begin
            logic b = (i < len) ? bits[len-1-i] : 1'b0;
            r = {r[15:0], b};
            if (r[n]) r = r ^ pf;
        end
        return r[15:0];
    endfunction

    logic [15:0] f16;
    logic [3:0]  f4;
    int          n16, n4;

    task automatic run(input bit md, input logic [127:0] bits, input int len, input bit gaps);
        @(negedge clk);
        start_i = 1'b1; mode_i = md; bit_vld_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < len; i++) begin
            if (gaps && ($urandom % 3 == 0)) begin
                bit_vld_i = 1'b0; bit_i = 1'($urandom); bit_last_i = 1'($urandom);
                @(negedge clk);
            end
            bit_vld_i = 1'b1; bit_i = bits[len-1-i]; bit_last_i = (i == len-1);
            @(negedge clk);
        end
        bit_vld_i = 1'b0; bit_last_i = 1'b0;
        f16 = '0; f4 = '0; n16 = 0; n4 = 0;
        if (!md) begin
            for (int c = 0; c < 16; c++) begin
                if (v16) begin n16++; f16 = {f16[14:0], b16}; end
                if (v4)  begin n4++;  f4  = {f4[2:0], b4}; end
                if (c == 4) check(d4 && !v4, "R4 w4 done after drain", {v4, d4}, 2'b01);
                @(negedge clk);
            end
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++; checks++;
                $display("FAIL watchdog actual=%0d expected<=100000", cycles);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [127:0] m, fr;
        logic [15:0]  exp16;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(!d16 && !e16 && !v16 && !d4 && !e4 && !v4, "R1 reset outputs",
              {d16, e16, v16, d4, e4, v4}, 0);

        // R3 worked case, also R2 on the wide instance
        m = 128'b1101011011;
        run(1'b0, m, 10, 1'b0);
        check(f4 == 4'b1110, "R3 fcs", f4, 4'b1110);
        check(n4 == 4, "R2 w4 fcs length", n4, 4);
        check(f16 == ref_rem(P16, 16, m, 10, 1'b1), "R2 w16 fcs", f16, ref_rem(P16, 16, m, 10, 1'b1));
        check(n16 == 16 && d16 && !e16, "R4 w16 done, no error", {n16[7:0], d16, e16}, {8'd16, 2'b10});
        // R4 hold: ignored inputs while done
        for (int k = 0; k < 5; k++) begin
            bit_vld_i = 1'($urandom); bit_i = 1'($urandom); bit_last_i = 1'($urandom);
            @(negedge clk);
        end
        bit_vld_i = 1'b0; bit_last_i = 1'b0;
        check(d16 && d4 && !v16 && !v4 && !e16, "R4 done held", {d16, d4, v16, v4, e16}, 5'b11000);

        // R5 worked frame on the narrow instance
        run(1'b1, 128'b11010110111110, 14, 1'b0);
        check(d4 && !e4, "R5 worked frame clean", {d4, e4}, 2'b10);

        // R2/R8 random messages, with and without gaps
        for (int t = 0; t < 24; t++) begin
            int len = 1 + ($urandom % 48);
            m = {$urandom, $urandom};
            m = m & ((128'd1 << len) - 1);
            run(1'b0, m, len, t[0]);
            check(f16 == ref_rem(P16, 16, m, len, 1'b1), t[0] ? "R8 w16 fcs with gaps" : "R2 w16 fcs",
                  f16, ref_rem(P16, 16, m, len, 1'b1));
            check(f4 == ref_rem(P4, 4, m, len, 1'b1), "R2 w4 fcs", f4, ref_rem(P4, 4, m, len, 1'b1));
            check(n16 == 16 && d16 && !e16, "R4 generate end", {n16[7:0], d16, e16}, {8'd16, 2'b10});
        end

        // R5 clean frames and random frames
        for (int t = 0; t < 10; t++) begin
            int len = 8 + ($urandom % 40);
            m = {$urandom, $urandom};
            m = m & ((128'd1 << len) - 1);
            exp16 = ref_rem(P16, 16, m, len, 1'b1);
            fr = (m << 16) | exp16;
            run(1'b1, fr, len + 16, t[0]);
            check(d16 && !e16, "R5 clean frame", {d16, e16}, 2'b10);
            fr = {$urandom, $urandom};
            run(1'b1, fr, 40, 1'b0);
            check(e16 == (ref_rem(P16, 16, fr, 40, 1'b0) != 0), "R5 random frame", e16,
                  ref_rem(P16, 16, fr, 40, 1'b0) != 0);
        end

        // R6 every single-bit flip in one frame
        m = 128'hA5C3_1E7B & 128'hFFFFFF;
        exp16 = ref_rem(P16, 16, m, 24, 1'b1);
        for (int p = 0; p < 40; p++) begin
            fr = ((m << 16) | exp16) ^ (128'd1 << p);
            run(1'b1, fr, 40, 1'b0);
            check(d16 && e16, "R6 single-bit flip", {d16, e16}, 2'b11);
        end

        // R7 bursts up to 16 bits
        for (int t = 0; t < 30; t++) begin
            int blen = 1 + ($urandom % 16);
            int pos;
            logic [127:0] pat;
            m = {$urandom} & 128'hFFFFFF;
            exp16 = ref_rem(P16, 16, m, 24, 1'b1);
            pat = ({$urandom} & ((128'd1 << blen) - 1)) | 128'd1 | (128'd1 << (blen - 1));
            pos = $urandom % (40 - blen + 1);
            fr = ((m << 16) | exp16) ^ (pat << pos);
            run(1'b1, fr, 40, 1'b0);
            check(d16 && e16, "R7 burst detected", {d16, e16}, 2'b11);
        end

        // R9 abort mid-job and restart
        @(negedge clk);
        start_i = 1'b1; mode_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < 7; i++) begin
            bit_vld_i = 1'b1; bit_i = 1'($urandom); bit_last_i = 1'b0;
            @(negedge clk);
        end
        bit_vld_i = 1'b0;
        start_i = 1'b1; mode_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        check(!d16 && !v16 && !d4, "R9 cleared by start", {d16, v16, d4}, 0);
        m = 128'h3C5A;
        run(1'b0, m, 16, 1'b0);
        check(f16 == ref_rem(P16, 16, m, 16, 1'b1), "R9 result after abort", f16,
              ref_rem(P16, 16, m, 16, 1'b1));

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule